// File: doc/BRIEF.md
# Block-Transfer Halt and Clock Realignment Sequencer

This block brackets a CPU-halting block transfer. A write to the channel-enable trigger arms it. The CPU is then allowed to finish one more bus cycle, and after that it is frozen. The sequencer waits for the next edge of a free-running transfer clock with a period of 8 master cycles. It then emits one transfer strobe per byte, channel by channel. When the last byte is done, it waits for a boundary of the CPU's own cycle length before it releases the CPU.

Every timing decision is made in master-clock cycles. The transfer clock runs from reset and never pauses, so the cost of the entry alignment depends on where the halt lands in that clock. The cost of the exit alignment depends on the speed of the CPU bus cycle that will follow the pause, which is 6, 8 or 12 master cycles. While it is transferring, the sequencer also guards the engine's bus: it blocks any access to the block's own register window and to the two trigger addresses. Address generation and the data buses themselves belong to neighbouring logic.

All control and status pins are plain level or pulse signals with no handshake. A transfer byte is a fixed-length slot on the transfer clock, so the sequencer cannot be back-pressured.

Top module: `dma_resync_ctrl`

## Requirements
- R1: A 3-bit transfer-clock phase counts master cycles modulo 8 from reset release, with phase 0 in the first cycle after reset. Every `xfer_stb` falls in a phase-0 cycle.
- R2: A `trig_we` cycle with a nonzero `trig_data` arms the block. The first `cpu_cycle_end` pulse in a later cycle ends the last CPU bus cycle, and `cpu_halt` rises in the cycle after that pulse. A trigger whose mask is all zero never halts the CPU.
- R3: The first strobe comes w cycles after the first halted cycle. w is the smallest value of at least 2 that lands on phase 0, so w falls between 2 and 9. `dma_active` is only ever high while `cpu_halt` is high.
- R4: Each byte occupies one 8-cycle slot. Strobes are exactly 8 cycles apart, and `dma_active` stays high for exactly 8 x N cycles, where N is the total byte count.
- R5: Enabled channels are served in ascending index order. Each channel gets as many bytes as its 16-bit count in `chan_count[16*i +: 16]`, and a count of 0 means 65536 bytes. `xfer_chan` gives the channel of each strobe.
- R6: `next_speed` is sampled with the releasing `cpu_cycle_end` and sets the cycle length L: 00 gives 6, 01 gives 8, and 10 or 11 give 12. The halt lasts H cycles, where H is the smallest multiple of L that is at least w + 8N + 2. `resume_stb` pulses for one cycle, in the first cycle in which `cpu_halt` is low again.
- R7: A trigger write made while a transfer is pending or running is ignored. It does not change the byte count, and it causes no second halt.
- R8: On a strobe, an engine access to 0x4300-0x437F, 0x420B or 0x420C is blocked. A write gives `bus_wr_en`=0. A read gives `bus_rd_en`=0 and `open_bus_sel`=1. Any other address gives `bus_wr_en` for a write or `bus_rd_en` for a read.
- R9: During and after reset, `cpu_halt`, `dma_active`, `xfer_stb`, `resume_stb`, `bus_rd_en` and `bus_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_we | input | 1 | Write strobe for the channel-enable trigger |
| trig_data | input | NCH | Channel-enable mask |
| chan_count | input | NCH*CW | Byte count per channel; 0 means 65536 |
| cpu_cycle_end | input | 1 | Pulse in the last master cycle of each CPU bus cycle |
| next_speed | input | 2 | Length code of the next CPU bus cycle |
| eng_addr | input | AW | Address the transfer engine is about to access |
| eng_write | input | 1 | 1 for an engine write, 0 for an engine read |
| cpu_halt | output | 1 | CPU is frozen |
| dma_active | output | 1 | Byte slots are running |
| xfer_stb | output | 1 | Start of one byte transfer |
| xfer_chan | output | $clog2(NCH) | Channel of the current byte |
| bus_rd_en | output | 1 | Engine read allowed |
| bus_wr_en | output | 1 | Engine write allowed |
| open_bus_sel | output | 1 | Engine read returns open-bus data |
| resume_stb | output | 1 | CPU restarts this cycle |

## Verification
A table of runs pairs each of the eight transfer-clock phases with each cycle-length code. This separates an entry-alignment error, which moves the first strobe, from an exit-alignment error, which changes only the halt length. The masks in the table range from one channel to all eight, with uneven counts, so the service order and the per-channel byte budgets are tested separately from the timing. Directed runs cover the all-zero mask, a repeated trigger during a transfer, a zero count that must not end the channel early, and an engine address list that hits both edges of the protected window, both trigger addresses and their neighbours.

// File: rtl/dmarc_pkg.sv
package dmarc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SYNC_IN,
    ST_XFER,
    ST_SYNC_OUT
  } seq_state_t;

  typedef enum logic [1:0] {
    SPD_FAST = 2'b00,
    SPD_MID  = 2'b01,
    SPD_SLOW = 2'b10,
    SPD_SLOW_ALT = 2'b11
  } cpu_speed_t;

endpackage

// File: rtl/dmarc_phase_gen.sv
module dmarc_phase_gen #(
  parameter int PERIOD = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [$clog2(PERIOD)-1:0] phase,
  output logic                      at_zero,
  output logic                      at_last
);
  localparam int PW = $clog2(PERIOD);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_q == PW'(PERIOD - 1)) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign phase   = ph_q;
  assign at_zero = (ph_q == '0);
  assign at_last = (ph_q == PW'(PERIOD - 1));
endmodule

// File: rtl/dmarc_chan_sched.sv
module dmarc_chan_sched #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NCH-1:0]           load_mask,
  input  logic                     take,
  input  logic [NCH*CW-1:0]        chan_count,
  output logic [$clog2(NCH)-1:0]   cur_chan,
  output logic                     all_done
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0] pend_q;
  logic [CW:0]    rem_q;
  logic           first_q;
  logic           done_q;

  logic [CW-1:0]  cnt_arr [NCH];
  logic [CHW-1:0] sel;
  logic [NCH-1:0] sel_oh;
  logic [CW-1:0]  cnt_sel;
  logic [CW:0]    eff;
  logic [CW:0]    rem_after;
  logic           others;

  for (genvar g = 0; g < NCH; g++) begin : g_cnt
    assign cnt_arr[g] = chan_count[g*CW +: CW];
  end

  // lowest pending channel wins
  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = CHW'(i);
    end
  end

  assign sel_oh    = NCH'(1) << sel;
  assign cnt_sel   = cnt_arr[sel];
  assign eff       = (cnt_sel == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cnt_sel};
  assign rem_after = (first_q ? eff : rem_q) - (CW+1)'(1);
  assign others    = |(pend_q & ~sel_oh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      rem_q   <= '0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (load) begin
      pend_q  <= load_mask;
      rem_q   <= '0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (take) begin
      if (rem_after == '0) begin
        pend_q  <= pend_q & ~sel_oh;
        first_q <= 1'b1;
        if (!others) done_q <= 1'b1;
      end else begin
        rem_q   <= rem_after;
        first_q <= 1'b0;
      end
    end
  end

  assign cur_chan = sel;
  assign all_done = done_q;
endmodule

// File: rtl/dmarc_seq_fsm.sv
module dmarc_seq_fsm
  import dmarc_pkg::*;
#(
  parameter int CYC_FAST = 6,
  parameter int CYC_MID  = 8,
  parameter int CYC_SLOW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_we,
  input  logic       trig_nonzero,
  input  logic       cpu_cycle_end,
  input  logic [1:0] next_speed,
  input  logic       dma_at_zero,
  input  logic       dma_at_last,
  input  logic       last_done,
  output logic       load,
  output logic       cpu_halt,
  output logic       dma_active,
  output logic       xfer_stb,
  output logic       resume_stb
);
  localparam int LW = $clog2(CYC_SLOW);

  seq_state_t state_q;
  logic [LW-1:0] len_m1_q;
  logic [LW-1:0] cpu_ph_q;
  logic [1:0]    sc_q;
  logic          resume_q;
  logic [LW-1:0] len_sel;
  logic          enter_halt;
  logic          enter_out;
  logic          leave_in;
  logic          leave_out;

  always_comb begin
    case (cpu_speed_t'(next_speed))
      SPD_FAST: len_sel = LW'(CYC_FAST - 1);
      SPD_MID:  len_sel = LW'(CYC_MID - 1);
      default:  len_sel = LW'(CYC_SLOW - 1);
    endcase
  end

  assign load       = (state_q == ST_IDLE) && trig_we && trig_nonzero;
  assign enter_halt = (state_q == ST_ARM) && cpu_cycle_end;
  assign leave_in   = (state_q == ST_SYNC_IN) && (sc_q != 2'd0) && dma_at_last;
  assign enter_out  = (state_q == ST_XFER) && dma_at_last && last_done;
  assign leave_out  = (state_q == ST_SYNC_OUT) && (sc_q != 2'd0) && (cpu_ph_q == len_m1_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:     if (load)       state_q <= ST_ARM;
        ST_ARM:      if (enter_halt) state_q <= ST_SYNC_IN;
        ST_SYNC_IN:  if (leave_in)   state_q <= ST_XFER;
        ST_XFER:     if (enter_out)  state_q <= ST_SYNC_OUT;
        ST_SYNC_OUT: if (leave_out)  state_q <= ST_IDLE;
        default:                     state_q <= ST_IDLE;
      endcase
    end
  end

  // CPU-cycle phase counted from the first halted cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1_q <= LW'(CYC_SLOW - 1);
      cpu_ph_q <= '0;
    end else if (enter_halt) begin
      len_m1_q <= len_sel;
      cpu_ph_q <= '0;
    end else if (cpu_ph_q == len_m1_q) begin
      cpu_ph_q <= '0;
    end else begin
      cpu_ph_q <= cpu_ph_q + 1'b1;
    end
  end

  // minimum-gap counter for both alignments
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= '0;
    end else if (enter_halt || enter_out) begin
      sc_q <= '0;
    end else if (sc_q != 2'd3) begin
      sc_q <= sc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resume_q <= 1'b0;
    else        resume_q <= leave_out;
  end

  assign cpu_halt   = (state_q == ST_SYNC_IN) || (state_q == ST_XFER) ||
                      (state_q == ST_SYNC_OUT);
  assign dma_active = (state_q == ST_XFER);
  assign xfer_stb   = (state_q == ST_XFER) && dma_at_zero;
  assign resume_stb = resume_q;
endmodule

// File: rtl/dmarc_win_guard.sv
module dmarc_win_guard #(
  parameter int          AW     = 16,
  parameter int unsigned WIN_LO = 32'h4300,
  parameter int unsigned WIN_HI = 32'h437F,
  parameter int unsigned TRIG_A = 32'h420B,
  parameter int unsigned TRIG_B = 32'h420C
) (
  input  logic          stb,
  input  logic [AW-1:0] eng_addr,
  input  logic          eng_write,
  output logic          bus_rd_en,
  output logic          bus_wr_en,
  output logic          open_bus_sel
);
  logic in_win;
  logic is_trig;
  logic blocked;

  assign in_win  = (eng_addr >= AW'(WIN_LO)) && (eng_addr <= AW'(WIN_HI));
  assign is_trig = (eng_addr == AW'(TRIG_A)) || (eng_addr == AW'(TRIG_B));
  assign blocked = in_win || is_trig;

  assign bus_wr_en    = stb && eng_write && !blocked;
  assign bus_rd_en    = stb && !eng_write && !blocked;
  assign open_bus_sel = stb && !eng_write && blocked;
endmodule

// File: rtl/dma_resync_ctrl.sv
module dma_resync_ctrl #(
  parameter int NCH      = 8,
  parameter int CW       = 16,
  parameter int AW       = 16,
  parameter int PERIOD   = 8,
  parameter int CYC_FAST = 6,
  parameter int CYC_MID  = 8,
  parameter int CYC_SLOW = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_we,
  input  logic [NCH-1:0]          trig_data,
  input  logic [NCH*CW-1:0]       chan_count,
  input  logic                    cpu_cycle_end,
  input  logic [1:0]              next_speed,
  input  logic [AW-1:0]           eng_addr,
  input  logic                    eng_write,
  output logic                    cpu_halt,
  output logic                    dma_active,
  output logic                    xfer_stb,
  output logic [$clog2(NCH)-1:0]  xfer_chan,
  output logic                    bus_rd_en,
  output logic                    bus_wr_en,
  output logic                    open_bus_sel,
  output logic                    resume_stb
);
  localparam int PW = $clog2(PERIOD);

  logic [PW-1:0] phase;
  logic          at_zero;
  logic          at_last;
  logic          load;
  logic          last_done;
  logic          stb;

  dmarc_phase_gen #(.PERIOD(PERIOD)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .at_zero (at_zero),
    .at_last (at_last)
  );

  dmarc_seq_fsm #(
    .CYC_FAST (CYC_FAST),
    .CYC_MID  (CYC_MID),
    .CYC_SLOW (CYC_SLOW)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_we       (trig_we),
    .trig_nonzero  (|trig_data),
    .cpu_cycle_end (cpu_cycle_end),
    .next_speed    (next_speed),
    .dma_at_zero   (at_zero),
    .dma_at_last   (at_last),
    .last_done     (last_done),
    .load          (load),
    .cpu_halt      (cpu_halt),
    .dma_active    (dma_active),
    .xfer_stb      (stb),
    .resume_stb    (resume_stb)
  );

  dmarc_chan_sched #(.NCH(NCH), .CW(CW)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_mask  (trig_data),
    .take       (stb),
    .chan_count (chan_count),
    .cur_chan   (xfer_chan),
    .all_done   (last_done)
  );

  dmarc_win_guard #(.AW(AW)) u_guard (
    .stb          (stb),
    .eng_addr     (eng_addr),
    .eng_write    (eng_write),
    .bus_rd_en    (bus_rd_en),
    .bus_wr_en    (bus_wr_en),
    .open_bus_sel (open_bus_sel)
  );

  assign xfer_stb = stb;
endmodule

// File: rtl/dmarc_checker.sv
module dmarc_checker #(
  parameter int NCH    = 8,
  parameter int AW     = 16,
  parameter int PERIOD = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          eng_addr,
  input logic                   eng_write,
  input logic                   cpu_halt,
  input logic                   dma_active,
  input logic                   xfer_stb,
  input logic                   bus_rd_en,
  input logic                   bus_wr_en,
  input logic                   open_bus_sel,
  input logic                   resume_stb
);
  logic [$clog2(PERIOD)-1:0] ck_ph;
  logic                      prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_ph <= '0;
    else        ck_ph <= ck_ph + 1'b1;
  end

  assign prot = ((eng_addr >= AW'(16'h4300)) && (eng_addr <= AW'(16'h437F))) ||
                (eng_addr == AW'(16'h420B)) || (eng_addr == AW'(16'h420C));

  p_stb_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> (ck_ph == '0));

  p_active_in_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> cpu_halt);

  p_stb_in_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> dma_active);

  p_resume_after_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_stb |-> (!cpu_halt && $past(cpu_halt)));

  p_resume_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_stb |=> !resume_stb);

  p_no_prot_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |-> !prot);

  p_prot_read_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && !eng_write && prot) |-> (open_bus_sel && !bus_rd_en));

  p_bus_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_active |-> !(bus_rd_en || bus_wr_en || open_bus_sel));
endmodule

bind dma_resync_ctrl dmarc_checker #(
  .NCH    (NCH),
  .AW     (AW),
  .PERIOD (PERIOD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_addr     (eng_addr),
  .eng_write    (eng_write),
  .cpu_halt     (cpu_halt),
  .dma_active   (dma_active),
  .xfer_stb     (xfer_stb),
  .bus_rd_en    (bus_rd_en),
  .bus_wr_en    (bus_wr_en),
  .open_bus_sel (open_bus_sel),
  .resume_stb   (resume_stb)
);

// File: tb/dma_resync_ctrl_tb.sv
module dma_resync_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int AW  = 16;

  // {mask, speed, phase, base count}
  localparam logic [20:0] VEC [26] = '{
    {8'h01, 2'd0, 3'd0, 8'd1}, {8'h02, 2'd0, 3'd1, 8'd2},
    {8'h04, 2'd0, 3'd2, 8'd1}, {8'h08, 2'd0, 3'd3, 8'd3},
    {8'h10, 2'd0, 3'd4, 8'd1}, {8'h20, 2'd0, 3'd5, 8'd2},
    {8'h40, 2'd0, 3'd6, 8'd1}, {8'h80, 2'd0, 3'd7, 8'd4},
    {8'h03, 2'd1, 3'd0, 8'd1}, {8'h81, 2'd1, 3'd1, 8'd1},
    {8'h11, 2'd1, 3'd2, 8'd2}, {8'h01, 2'd1, 3'd3, 8'd1},
    {8'hC0, 2'd1, 3'd4, 8'd1}, {8'h24, 2'd1, 3'd5, 8'd3},
    {8'h02, 2'd1, 3'd6, 8'd5}, {8'hFF, 2'd1, 3'd7, 8'd1},
    {8'h01, 2'd2, 3'd0, 8'd2}, {8'h05, 2'd2, 3'd1, 8'd1},
    {8'h18, 2'd2, 3'd2, 8'd1}, {8'h20, 2'd2, 3'd3, 8'd1},
    {8'h01, 2'd2, 3'd4, 8'd7}, {8'h42, 2'd2, 3'd5, 8'd2},
    {8'h0F, 2'd2, 3'd6, 8'd1}, {8'h80, 2'd2, 3'd7, 8'd3},
    {8'h01, 2'd3, 3'd3, 8'd1}, {8'h10, 2'd3, 3'd6, 8'd2}
  };

  // {write, address} applied to successive strobes
  localparam logic [16:0] GADDR [8] = '{
    {1'b1, 16'h4300}, {1'b0, 16'h437F}, {1'b1, 16'h4380}, {1'b1, 16'h420B},
    {1'b0, 16'h420C}, {1'b1, 16'h420A}, {1'b0, 16'h42FF}, {1'b1, 16'h2118}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              trig_we = 1'b0;
  logic [NCH-1:0]    trig_data = '0;
  logic [NCH*CW-1:0] chan_count = '0;
  logic              cpu_cycle_end = 1'b0;
  logic [1:0]        next_speed = 2'b00;
  logic [AW-1:0]     eng_addr = '0;
  logic              eng_write = 1'b0;
  logic              cpu_halt, dma_active, xfer_stb, bus_rd_en, bus_wr_en;
  logic              open_bus_sel, resume_stb;
  logic [2:0]        xfer_chan;

  int checks = 0;
  int errors = 0;
  int cyc;
  bit done = 0;

  bit mon_on = 0;
  int h, r, n_stb, act_n;
  int stb_cyc [256];
  int stb_ch  [256];
  bit stb_rd [256];
  bit stb_wr [256];
  bit stb_op [256];

  dma_resync_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .trig_we (trig_we), .trig_data (trig_data),
    .chan_count (chan_count), .cpu_cycle_end (cpu_cycle_end),
    .next_speed (next_speed), .eng_addr (eng_addr), .eng_write (eng_write),
    .cpu_halt (cpu_halt), .dma_active (dma_active), .xfer_stb (xfer_stb),
    .xfer_chan (xfer_chan), .bus_rd_en (bus_rd_en), .bus_wr_en (bus_wr_en),
    .open_bus_sel (open_bus_sel), .resume_stb (resume_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    #1;
    {eng_write, eng_addr} = GADDR[n_stb % 8];
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (cpu_halt && h < 0) h = cyc;
      if (dma_active) act_n++;
      if (xfer_stb && n_stb < 256) begin
        stb_cyc[n_stb] = cyc;
        stb_ch[n_stb]  = int'(xfer_chan);
        stb_rd[n_stb]  = bus_rd_en;
        stb_wr[n_stb]  = bus_wr_en;
        stb_op[n_stb]  = open_bus_sel;
        n_stb++;
      end
      if (resume_stb && r < 0) r = cyc;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    h = -1; r = -1; n_stb = 0; act_n = 0;
  endtask

  task automatic set_counts(input int base);
    for (int i = 0; i < NCH; i++) chan_count[i*CW +: CW] = CW'(base + i);
  endtask

  task automatic run_case(input logic [7:0] mask, input logic [1:0] spd,
                          input int phase, input int base, input bit mid_trig);
    int e, w, p, n_exp, len, hlen, k, bad;
    @(negedge clk);
    set_counts(base);
    mon_clear();
    mon_on = 1;
    trig_we = 1'b1; trig_data = mask;
    @(negedge clk);
    trig_we = 1'b0; trig_data = '0;
    while (((cyc + 1) % 8) != phase) @(negedge clk);
    cpu_cycle_end = 1'b1; next_speed = spd; e = cyc;
    @(negedge clk);
    cpu_cycle_end = 1'b0; next_speed = spd ^ 2'b01;
    if (mid_trig) begin
      while (!dma_active) @(negedge clk);
      trig_we = 1'b1; trig_data = 8'hFF;
      @(negedge clk);
      trig_we = 1'b0; trig_data = '0;
    end
    for (int t = 0; t < 5000 && r < 0; t++) @(negedge clk);
    @(negedge clk);
    mon_on = 0;

    p = (e + 1) % 8;
    w = (8 - p) % 8;
    if (w < 2) w += 8;
    n_exp = 0;
    for (int i = 0; i < NCH; i++) if (mask[i]) n_exp += base + i;
    len = (spd == 2'b00) ? 6 : (spd == 2'b01) ? 8 : 12;
    hlen = ((w + 8*n_exp + 2 + len - 1) / len) * len;

    chk("R2", "halt start cycle", h, e + 1);
    chk("R3", "first strobe cycle", stb_cyc[0], e + 1 + w);
    chk("R4", "active cycles", act_n, 8*n_exp);
    chk("R5", "strobe count", n_stb, n_exp);
    chk("R6", "resume cycle", r, e + 1 + hlen);
    bad = 0;
    k = 0;
    for (int i = 0; i < NCH; i++) begin
      if (mask[i]) begin
        for (int b = 0; b < base + i; b++) begin
          if (k < 256 && stb_ch[k] != i) bad++;
          k++;
        end
      end
    end
    chk("R5", "channel order mismatches", bad, 0);
    bad = 0;
    for (int j = 0; j < n_stb; j++) begin
      if (stb_cyc[j] != e + 1 + w + 8*j) bad++;
      if ((stb_cyc[j] % 8) != 0) bad++;
    end
    chk("R1", "strobe spacing/phase mismatches", bad, 0);
  endtask

  initial begin
    bit prot, wr;
    mon_clear();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "halt in reset", cpu_halt, 0);
    chk("R9", "active in reset", dma_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "strobe after reset", xfer_stb, 0);
    chk("R9", "resume after reset", resume_stb, 0);
    chk("R9", "bus enables after reset", bus_rd_en | bus_wr_en, 0);

    // table walk: every phase against every length code
    for (int v = 0; v < 26; v++) begin
      run_case(VEC[v][20:13], VEC[v][12:11], int'(VEC[v][10:8]), int'(VEC[v][7:0]), 1'b0);
      repeat (3) @(negedge clk);
    end

    // R2: all-zero mask never halts
    mon_clear(); mon_on = 1;
    trig_we = 1'b1; trig_data = 8'h00;
    @(negedge clk); trig_we = 1'b0;
    cpu_cycle_end = 1'b1;
    @(negedge clk); cpu_cycle_end = 1'b0;
    repeat (30) @(negedge clk);
    mon_on = 0;
    chk("R2", "halt after zero mask", h, -1);

    // R7: trigger during a transfer is ignored
    run_case(8'h06, 2'b01, 5, 2, 1'b1);
    mon_clear(); mon_on = 1;
    cpu_cycle_end = 1'b1;
    @(negedge clk); cpu_cycle_end = 1'b0;
    repeat (40) @(negedge clk);
    mon_on = 0;
    chk("R7", "second halt after busy trigger", h, -1);

    // R8: protected window on the engine bus
    run_case(8'h01, 2'b00, 3, 8, 1'b0);
    for (int j = 0; j < 8; j++) begin
      wr = GADDR[j][16];
      prot = ((GADDR[j][15:0] >= 16'h4300) && (GADDR[j][15:0] <= 16'h437F)) ||
             (GADDR[j][15:0] == 16'h420B) || (GADDR[j][15:0] == 16'h420C);
      chk("R8", $sformatf("wr_en addr %h", GADDR[j][15:0]), stb_wr[j], wr && !prot);
      chk("R8", $sformatf("rd_en addr %h", GADDR[j][15:0]), stb_rd[j], !wr && !prot);
      chk("R8", $sformatf("open addr %h", GADDR[j][15:0]), stb_op[j], !wr && prot);
    end

    // R5: count 0 is 65536 bytes, channel 0 must not end early
    @(negedge clk);
    chan_count = '0;
    chan_count[CW +: CW] = 16'd1;
    mon_clear(); mon_on = 1;
    trig_we = 1'b1; trig_data = 8'h03;
    @(negedge clk); trig_we = 1'b0; trig_data = '0;
    cpu_cycle_end = 1'b1;
    @(negedge clk); cpu_cycle_end = 1'b0;
    while (n_stb < 100) @(negedge clk);
    mon_on = 0;
    begin
      int bad = 0;
      for (int j = 0; j < 100; j++) if (stb_ch[j] != 0) bad++;
      chk("R5", "zero-count channel strobes on other channel", bad, 0);
    end
    chk("R5", "still active on zero-count channel", dma_active, 1);

    // R9: reset mid-transfer
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "halt during reset", cpu_halt, 0);
    chk("R9", "active during reset", dma_active, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9", "halt after reset", cpu_halt, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule